// File: doc/BRIEF.md
# Pattern-Count Packet Annotator

This block sits in a byte-wide stream of IPv4/UDP packets and counts how often the five-character sequence `corn!` (0x63, 0x6F, 0x72, 0x6E, 0x21) appears in each packet's UDP payload. It steps over a fixed 20-byte IPv4 header and the 8-byte UDP header, and takes the UDP length from the two length bytes. Every byte then leaves the block one cycle later, unchanged, with one exception. The last byte of the UDP segment is replaced by the number of matches found in that packet.

The input carries a valid strobe, a start-of-packet flag on the first byte and an end-of-packet flag on the last byte. Cycles with the valid strobe low are bubbles and the block ignores their data. A running byte position is compared with the captured length to find the byte that gets overwritten. That comparison is pure combinational logic ahead of the output register.

Top module: `annot_top`

## Requirements
- R1: A payload byte 0x21 that arrives directly after the valid bytes 0x63, 0x6F, 0x72, 0x6E raises a one-cycle internal match pulse. Each such pulse adds one to the packet's match count.
- R2: A payload byte that is not the next expected character abandons the partial match. If that byte is 0x63, it is taken as the first character of a new candidate, so `ccorn!` and `cocorn!` each still count once.
- R3: Only cycles with in_valid high advance the matcher and the counters. A cycle with in_valid low produces out_valid low on the next cycle, and the data it carries has no effect on any count.
- R4: Packet bytes 0 to 27 (the IPv4 and UDP headers) never contribute to the match count, even if they contain the pattern.
- R5: The UDP length is taken big-endian from packet bytes 24 (high) and 25 (low), with a one-cycle capture pulse on byte 25. A length of 8 places the annotated byte at packet index 27.
- R6: The byte at packet index 19 + UDP length leaves the block as the match count. That count includes a match whose final character is that same byte.
- R7: Every other valid byte is forwarded unchanged exactly one cycle later, and out_valid, out_sop and out_eop are aligned with it.
- R8: The match count and the byte position restart at each start-of-packet byte, so counts never carry over from one packet to the next.
- R9: The match count saturates at 255 and does not wrap.
- R10: While rst is high, out_valid, out_sop and out_eop are low and out_data is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_eop | input | 1 | Input byte is the last byte of a packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid, one cycle behind in_valid |
| out_sop | output | 1 | Start-of-packet flag aligned with out_data |
| out_eop | output | 1 | End-of-packet flag aligned with out_data |
| out_data | output | 8 | Forwarded byte, or the match count on the annotated position |

## Verification
Several properties are checked on every cycle:
- the one-cycle timing of valid and start-of-packet;
- unchanged forwarding of any byte that is not the annotated one;
- a match pulse only when a valid 0x21 arrives;
- the single-cycle length capture pulse;
- the count staying pinned at 255 once it is saturated.

Some behaviours only the bench scenarios can show, by comparing against a reference built from the packet contents:
- that the count is correct, including overlapping `c` restarts;
- that header bytes and bubble data are ignored;
- that the annotated byte lands where the captured length says;
- that counts restart between back-to-back packets.

// File: rtl/annot_pkg.sv
package annot_pkg;

    localparam int BYTE_W        = 8;
    localparam int LEN_W         = 2 * BYTE_W;
    localparam int IP_HDR_BYTES  = 20;
    localparam int PORT_BYTES    = 4;
    localparam int UDP_HDR_BYTES = 8;
    localparam int LEN_HI_IDX    = IP_HDR_BYTES + PORT_BYTES;
    localparam int PAYLOAD_IDX   = IP_HDR_BYTES + UDP_HDR_BYTES;

    localparam logic [BYTE_W-1:0] CH_C    = 8'h63;
    localparam logic [BYTE_W-1:0] CH_O    = 8'h6F;
    localparam logic [BYTE_W-1:0] CH_R    = 8'h72;
    localparam logic [BYTE_W-1:0] CH_N    = 8'h6E;
    localparam logic [BYTE_W-1:0] CH_BANG = 8'h21;

    typedef enum logic [3:0] {
        WK_IPHDR,
        WK_PORTS,
        WK_LEN_HI,
        WK_LEN_LO,
        WK_CSUM,
        WK_SCAN,
        WK_GOT_C,
        WK_GOT_O,
        WK_GOT_R,
        WK_GOT_N
    } walk_state_t;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BYTE_W-1:0] data;
    } beat_t;

    // Next scanning state for one payload byte; a stray 'c' opens a new candidate.
    function automatic walk_state_t scan_step(walk_state_t st, logic [BYTE_W-1:0] b);
        walk_state_t nx;
        nx = (b == CH_C) ? WK_GOT_C : WK_SCAN;
        case (st)
            WK_GOT_C: if (b == CH_O) nx = WK_GOT_O;
            WK_GOT_O: if (b == CH_R) nx = WK_GOT_R;
            WK_GOT_R: if (b == CH_N) nx = WK_GOT_N;
            default:  ;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/annot_ctr.sv
module annot_ctr #(
    parameter int W   = 8,
    parameter bit SAT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] inc_val,
    output logic [W-1:0] q
);

    logic [W-1:0] step_val;

    generate
        if (SAT) begin : g_sat
            logic [W:0] sum;
            assign sum      = {1'b0, q} + {1'b0, inc_val};
            assign step_val = sum[W] ? {W{1'b1}} : sum[W-1:0];
        end else begin : g_wrap
            assign step_val = q + inc_val;
        end
    endgenerate

    // clear beats load, load beats increment, otherwise hold
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= step_val;
        end
    end

endmodule

// File: rtl/annot_walker.sv
module annot_walker
    import annot_pkg::*;
#(
    parameter int POS_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_vld,
    input  logic              beat_sop,
    input  logic [BYTE_W-1:0] beat_data,
    input  logic [POS_W-1:0]  beat_idx,
    output logic              alert,
    output logic              len_vld,
    output logic [LEN_W-1:0]  len_val
);

    localparam logic [POS_W-1:0] IP_LAST   = POS_W'(IP_HDR_BYTES - 1);
    localparam logic [POS_W-1:0] PORT_LAST = POS_W'(LEN_HI_IDX - 1);
    localparam logic [POS_W-1:0] HDR_LAST  = POS_W'(PAYLOAD_IDX - 1);

    walk_state_t       st_q;
    walk_state_t       st_cur;
    walk_state_t       st_nx;
    logic [BYTE_W-1:0] len_hi_q;

    always_comb begin
        st_cur  = beat_sop ? WK_IPHDR : st_q;
        st_nx   = st_cur;
        alert   = 1'b0;
        len_vld = 1'b0;
        case (st_cur)
            WK_IPHDR:  if (beat_idx == IP_LAST)   st_nx = WK_PORTS;
            WK_PORTS:  if (beat_idx == PORT_LAST) st_nx = WK_LEN_HI;
            WK_LEN_HI: st_nx = WK_LEN_LO;
            WK_LEN_LO: begin
                len_vld = beat_vld;
                st_nx   = WK_CSUM;
            end
            WK_CSUM:   if (beat_idx == HDR_LAST)  st_nx = WK_SCAN;
            default: begin
                st_nx = scan_step(st_cur, beat_data);
                alert = beat_vld && (st_cur == WK_GOT_N) && (beat_data == CH_BANG);
            end
        endcase
    end

    assign len_val = {len_hi_q, beat_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= WK_IPHDR;
            len_hi_q <= '0;
        end else if (beat_vld) begin
            st_q <= st_nx;
            if (st_cur == WK_LEN_HI) begin
                len_hi_q <= beat_data;
            end
        end
    end

endmodule

// File: rtl/annot_top.sv
module annot_top
    import annot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [BYTE_W-1:0] out_data
);

    localparam int POS_W = LEN_W + 1;
    localparam logic [POS_W-1:0] LAST_OFS = POS_W'(IP_HDR_BYTES - 1);

    logic              sop_beat;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  byte_idx;
    logic [POS_W-1:0]  last_idx;
    logic              alert;
    logic              len_vld;
    logic [LEN_W-1:0]  len_val;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  match_cnt;
    logic [CNT_W-1:0]  cnt_now;
    logic              hit;
    beat_t             out_q;
    logic              out_vld_q;

    assign sop_beat = in_valid && in_sop;
    assign byte_idx = in_sop ? '0 : pos_q;

    annot_walker #(.POS_W(POS_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .beat_vld  (in_valid),
        .beat_sop  (in_sop),
        .beat_data (in_data),
        .beat_idx  (byte_idx),
        .alert     (alert),
        .len_vld   (len_vld),
        .len_val   (len_val)
    );

    // bytes seen so far in the current packet
    annot_ctr #(.W(POS_W), .SAT(1'b0)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .clr     (1'b0),
        .ld      (sop_beat),
        .inc     (in_valid),
        .ld_val  (POS_W'(1)),
        .inc_val (POS_W'(1)),
        .q       (pos_q)
    );

    annot_ctr #(.W(CNT_W), .SAT(1'b1)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (sop_beat),
        .ld      (1'b0),
        .inc     (alert),
        .ld_val  ('0),
        .inc_val (CNT_W'(1)),
        .q       (match_cnt)
    );

    annot_ctr #(.W(LEN_W), .SAT(1'b0)) u_len (
        .clk     (clk),
        .rst     (rst),
        .clr     (sop_beat),
        .ld      (len_vld),
        .inc     (1'b0),
        .ld_val  (len_val),
        .inc_val ('0),
        .q       (len_q)
    );

    assign last_idx = POS_W'(len_q) + LAST_OFS;
    assign hit      = in_valid && (len_q != '0) && (byte_idx == last_idx);
    assign cnt_now  = (alert && (match_cnt != {CNT_W{1'b1}})) ? match_cnt + CNT_W'(1) : match_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q <= 1'b0;
            out_q     <= '0;
        end else begin
            out_vld_q  <= in_valid;
            out_q.sop  <= sop_beat;
            out_q.eop  <= in_valid && in_eop;
            if (in_valid) begin
                out_q.data <= hit ? BYTE_W'(cnt_now) : in_data;
            end
        end
    end

    assign out_valid = out_vld_q;
    assign out_sop   = out_q.sop;
    assign out_eop   = out_q.eop;
    assign out_data  = out_q.data;

endmodule

// File: rtl/annot_checker.sv
module annot_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sop,
    input logic [7:0]       in_data,
    input logic             out_valid,
    input logic             out_sop,
    input logic [7:0]       out_data,
    input logic             alert,
    input logic             len_vld,
    input logic             hit,
    input logic [CNT_W-1:0] match_cnt
);

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

    AST_BUBBLE_PIPE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R3

    AST_SOP_PIPE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> out_sop); // R7

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hit) |=> (out_data == $past(in_data))); // R7

    AST_ALERT_ON_BANG: assert property (@(posedge clk) disable iff (rst)
        alert |-> (in_valid && in_data == 8'h21)); // R1

    AST_LEN_PULSE: assert property (@(posedge clk) disable iff (rst)
        len_vld |=> !len_vld); // R5

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        ((match_cnt == {CNT_W{1'b1}}) && !(in_valid && in_sop)) |=> (match_cnt == {CNT_W{1'b1}})); // R9

endmodule

bind annot_top annot_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data),
    .alert     (alert),
    .len_vld   (len_vld),
    .hit       (hit),
    .match_cnt (match_cnt)
);

// File: tb/annot_top_test.sv
module annot_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_sop;
    logic       out_eop;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    annot_top uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

    int         nchk = 0;
    int         nerr = 0;
    bit         finished = 0;
    logic [7:0] pkt[$];

    // expectation for the beat driven one cycle earlier
    bit         p_live = 0;
    bit         p_v, p_s, p_e;
    logic [7:0] p_d;
    string      p_tag;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit s, input bit e, input logic [7:0] d,
                        input logic [7:0] ed, input string tag);
        @(negedge clk);
        if (p_live) begin
            chk(out_valid === p_v, p_v ? "R7" : "R3", "out_valid", out_valid, p_v);
            if (p_v) begin
                chk(out_sop === p_s, "R7", "out_sop", out_sop, p_s);
                chk(out_eop === p_e, "R7", "out_eop", out_eop, p_e);
                chk(out_data === ed_q, p_tag, "out_data", out_data, ed_q);
            end
        end
        in_valid = v;
        in_sop   = s;
        in_eop   = e;
        in_data  = d;
        p_live = 1;
        p_v = v; p_s = s; p_e = e; p_d = d; p_tag = tag;
        ed_q = ed;
    endtask

    logic [7:0] ed_q;

    task automatic new_pkt(input bit trap);
        pkt.delete();
        for (int i = 0; i < 20; i++) pkt.push_back(i == 0 ? 8'h45 : 8'(i + 1));
        if (trap) begin
            pkt[12] = 8'h63; pkt[13] = 8'h6F; pkt[14] = 8'h72; pkt[15] = 8'h6E; pkt[16] = 8'h21;
        end
        pkt.push_back(8'h30); pkt.push_back(8'h39); pkt.push_back(8'h1F); pkt.push_back(8'h90);
        pkt.push_back(8'h00); pkt.push_back(8'h00);
        pkt.push_back(8'hA5); pkt.push_back(8'hA5);
    endtask

    task automatic add_str(input string s);
        for (int i = 0; i < s.len(); i++) pkt.push_back(s[i]);
    endtask

    function automatic int ref_count();
        int c = 0;
        int last = pkt.size() - 1;
        for (int i = 28; i + 4 <= last; i++) begin
            if (pkt[i] == 8'h63 && pkt[i+1] == 8'h6F && pkt[i+2] == 8'h72 &&
                pkt[i+3] == 8'h6E && pkt[i+4] == 8'h21) c++;
        end
        return (c > 255) ? 255 : c;
    endfunction

    task automatic send_pkt(input string tag, input bit gaps, input int exp_cnt);
        int ulen = pkt.size() - 20;
        int last = pkt.size() - 1;
        int cnt;
        pkt[24] = 8'(ulen >> 8);
        pkt[25] = 8'(ulen & 255);
        cnt = ref_count();
        chk(cnt == exp_cnt, tag, "reference count", cnt, exp_cnt);
        for (int i = 0; i <= last; i++) begin
            if (gaps && (i % 3 == 1)) step(0, 0, 0, 8'h78, 8'h00, "R3");
            step(1, i == 0, i == last, pkt[i], (i == last) ? 8'(cnt) : pkt[i],
                 (i == last) ? tag : "R7");
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid === 1'b0, "R10", "out_valid", out_valid, 0);
        chk(out_sop === 1'b0, "R10", "out_sop", out_sop, 0);
        chk(out_eop === 1'b0, "R10", "out_eop", out_eop, 0);
        chk(out_data === 8'h00, "R10", "out_data", out_data, 0);
        rst = 1'b0;

        // R1: a single match in the middle of the payload
        new_pkt(0); add_str("xxcorn!yy."); send_pkt("R1", 0, 1);
        // R2: broken candidates and 'c' restarts
        new_pkt(0); add_str("ccorn!corxcorn!cocorn!corn?."); send_pkt("R2", 0, 3);
        // R8: next packet back to back, count must restart
        new_pkt(0); add_str("nothing here."); send_pkt("R8", 0, 0);
        // R4: pattern inside the IP header is ignored
        new_pkt(1); add_str("none."); send_pkt("R4", 0, 0);
        // R3: bubbles carrying 'x' between valid bytes do not break matches
        new_pkt(0); add_str("corn!corn!."); send_pkt("R3", 1, 2);
        step(0, 0, 0, 8'h21, 8'h00, "R3");
        // R6: match completing on the annotated byte itself
        new_pkt(0); add_str("abcorn!"); send_pkt("R6", 0, 1);
        // R5: length 8, annotated byte is the second checksum byte
        new_pkt(0); send_pkt("R5", 0, 0);
        // R9: 300 matches saturate at 255
        new_pkt(0);
        for (int k = 0; k < 300; k++) add_str("corn!");
        add_str(".");
        send_pkt("R9", 0, 255);
        // R8: after saturation the next packet starts from zero
        new_pkt(0); add_str("corn!."); send_pkt("R8", 0, 1);

        step(0, 0, 0, 8'h00, 8'h00, "R3");
        step(0, 0, 0, 8'h00, 8'h00, "R3");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule